// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block connects a CPU register bus to a byte-wide parallel printer port. The CPU writes a data byte that is placed on the port lines. It writes a control byte whose low bits drive the four active-low handshake outputs to the printer: strobe, autofeed, initialize and select-in. It reads back a status byte built from the printer's busy, paper-out, selected, error and acknowledge lines, together with a latched print flag.

A printer interrupt output is gated by an enable bit in the control byte. Its enable doubles as the output-enable of the interrupt pin, so the pin floats after reset. A strap input picks the interrupt source. In one setting the interrupt follows the synchronized acknowledge line. In the other it follows the print flag, which a rising acknowledge sets and a status read clears. A second strap either fixes the port as an output or hands its direction to a control bit. A bus-buffer enable output is high while the CPU reads this port, and also while a neighbouring serial channel reports a read of its own.

Registers sit at address 0 (data), 1 (status) and 2 (control). The chip select and the read and write strobes are all active low. A write takes effect on the clock edge during which the write strobe is low.

Top module: `prn_port_ctrl`

## Requirements
- R1: After reset the control byte is 0x00, so strbN, afdN, initN and slinN are high. The data byte is 0x00, irqOe is low, and the print flag is clear.
- R2: Control bits 0, 1, 2 and 3 drive strbN, afdN, initN and slinN respectively, each inverted, from the clock edge after the write onward.
- R3: Reading address 2 returns all 8 bits last written to address 2.
- R4: With dirCtl low, pdOe stays high whatever control bit 5 holds. A read of address 0 then returns the written data byte, which also appears on pdOut.
- R5: With dirCtl high, control bit 5 set makes pdOe low, and a read of address 0 returns pdIn as sampled one clock earlier. With bit 5 clear, pdOe is high.
- R6: Reading address 1 returns {busy, ack, paperOut, selected, errN, printFlag, 2'b00}, from bit 7 down to bit 0. Here ack is the synchronized level of ackN.
- R7: A low-to-high transition of the synchronized ackN sets the print flag. The flag stays set until a status read clears it, and a set in the same cycle as a clear wins.
- R8: With irqMode low and control bit 4 set, irqOut equals the synchronized level of ackN.
- R9: With irqMode high and control bit 4 set, irqOut equals the print flag.
- R10: irqOe equals control bit 4, and irqOut is low whenever irqOe is low.
- R11: busEn is high exactly while the port is read (csN and rdN both low) or serialRead is high.
- R12: Reads of addresses 3 to 7 return 0x00. A write to address 1 changes neither the control byte nor the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | CPU read data, zero when not reading |
| busEn | output | 1 | Bus-buffer enable |
| serialRead | input | 1 | A serial channel is being read |
| pdOut | output | 8 | Port data driven to the printer |
| pdIn | input | 8 | Port data seen at the pins |
| pdOe | output | 1 | Port output enable |
| strbN | output | 1 | Active-low strobe |
| afdN | output | 1 | Active-low autofeed |
| initN | output | 1 | Active-low initialize |
| slinN | output | 1 | Active-low select-in |
| busy | input | 1 | Printer busy, active high |
| paperOut | input | 1 | Paper empty, active high |
| selected | input | 1 | Printer selected, active high |
| errN | input | 1 | Printer error, active low |
| ackN | input | 1 | Printer acknowledge, active low |
| irqMode | input | 1 | Interrupt source strap: 0 follows ack, 1 follows the print flag |
| dirCtl | input | 1 | Direction strap: 0 fixed output, 1 software direction |
| irqOut | output | 1 | Printer interrupt value |
| irqOe | output | 1 | Interrupt pin output enable |

## Verification
Some properties are checked on every cycle. These are the polarity of the handshake pins after a control write, the fixed output direction when dirCtl is low, agreement between a data read and pdOut in output direction, the gating of the interrupt by its enable, the bus-buffer enable during reads, and zero data from unused addresses. Other behaviour is shown only by the bench scenarios. That covers the print flag's set-by-edge and clear-by-read sequence, the two interrupt sources, the status bit layout under varied printer states, and the sampled input path in input direction. All of these depend on multi-cycle histories through the acknowledge synchronizer.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam logic [2:0] ADDR_DATA   = 3'd0;
  localparam logic [2:0] ADDR_STATUS = 3'd1;
  localparam logic [2:0] ADDR_CTRL   = 3'd2;

  localparam int CTRL_IRQ_BIT = 4;
  localparam int CTRL_DIR_BIT = 5;

  typedef struct packed {
    logic       wrData;
    logic       wrCtrl;
    logic       rdActive;
    logic       rdStatus;
    logic [2:0] rdSel;
  } prnStrobe_t;
endpackage

// File: rtl/prn_ctrl.sv
module prn_ctrl
  import prn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] addr,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       ackN,
  input  logic       irqMode,
  input  logic       irqEnable,
  output prnStrobe_t stb,
  output logic       ackSync,
  output logic       printFlag,
  output logic       irqOut
);
  logic [SYNC_STAGES-1:0] ackPipe;
  logic ackPrev;
  logic ackRise;
  logic wrActive;
  logic rdActive;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackPipe <= '1;
        else       ackPipe <= ackN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ackPipe <= '1;
        else       ackPipe <= {ackPipe[SYNC_STAGES-2:0], ackN};
      end
    end
  endgenerate

  assign ackSync  = ackPipe[SYNC_STAGES-1];
  assign ackRise  = ackSync & ~ackPrev;
  assign wrActive = ~csN & ~wrN;
  assign rdActive = ~csN & ~rdN;

  always_comb begin
    stb.wrData   = wrActive && (addr == ADDR_DATA);
    stb.wrCtrl   = wrActive && (addr == ADDR_CTRL);
    stb.rdActive = rdActive;
    stb.rdStatus = rdActive && (addr == ADDR_STATUS);
    stb.rdSel    = addr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackPrev   <= 1'b1;
      printFlag <= 1'b0;
    end else begin
      ackPrev <= ackSync;
      if (ackRise)           printFlag <= 1'b1;
      else if (stb.rdStatus) printFlag <= 1'b0;
    end
  end

  assign irqOut = irqEnable & (irqMode ? printFlag : ackSync);
endmodule

// File: rtl/prn_dp.sv
module prn_dp
  import prn_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  prnStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pdIn,
  input  logic              dirCtl,
  input  logic              busy,
  input  logic              paperOut,
  input  logic              selected,
  input  logic              errN,
  input  logic              ackSync,
  input  logic              printFlag,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pdOut,
  output logic              pdOe,
  output logic              strbN,
  output logic              afdN,
  output logic              initN,
  output logic              slinN,
  output logic              irqEnable
);
  localparam int PAD_W = DATA_W - 6;

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] pdSample;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      ctrlReg  <= '0;
      pdSample <= '0;
    end else begin
      pdSample <= pdIn;
      if (stb.wrData) dataReg <= wrData;
      if (stb.wrCtrl) ctrlReg <= wrData;
    end
  end

  assign pdOut     = dataReg;
  assign pdOe      = ~dirCtl | ~ctrlReg[CTRL_DIR_BIT];
  assign strbN     = ~ctrlReg[0];
  assign afdN      = ~ctrlReg[1];
  assign initN     = ~ctrlReg[2];
  assign slinN     = ~ctrlReg[3];
  assign irqEnable = ctrlReg[CTRL_IRQ_BIT];

  assign statusWord = {{(PAD_W-2){1'b0}}, busy, ackSync, paperOut, selected,
                       errN, printFlag, 2'b00};

  always_comb begin
    rdData = '0;
    if (stb.rdActive) begin
      case (stb.rdSel)
        ADDR_DATA:   rdData = pdOe ? dataReg : pdSample;
        ADDR_STATUS: rdData = statusWord;
        ADDR_CTRL:   rdData = ctrlReg;
        default:     rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/prn_port_ctrl.sv
module prn_port_ctrl
  import prn_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        addr,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              busEn,
  input  logic              serialRead,
  output logic [DATA_W-1:0] pdOut,
  input  logic [DATA_W-1:0] pdIn,
  output logic              pdOe,
  output logic              strbN,
  output logic              afdN,
  output logic              initN,
  output logic              slinN,
  input  logic              busy,
  input  logic              paperOut,
  input  logic              selected,
  input  logic              errN,
  input  logic              ackN,
  input  logic              irqMode,
  input  logic              dirCtl,
  output logic              irqOut,
  output logic              irqOe
);
  prnStrobe_t stb;
  logic ackSync;
  logic printFlag;
  logic irqEnable;

  prn_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .csN(csN), .rdN(rdN), .wrN(wrN),
    .ackN(ackN), .irqMode(irqMode), .irqEnable(irqEnable), .stb(stb),
    .ackSync(ackSync), .printFlag(printFlag), .irqOut(irqOut)
  );

  prn_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .pdIn(pdIn),
    .dirCtl(dirCtl), .busy(busy), .paperOut(paperOut), .selected(selected),
    .errN(errN), .ackSync(ackSync), .printFlag(printFlag), .rdData(rdData),
    .pdOut(pdOut), .pdOe(pdOe), .strbN(strbN), .afdN(afdN), .initN(initN),
    .slinN(slinN), .irqEnable(irqEnable)
  );

  assign irqOe = irqEnable;
  assign busEn = stb.rdActive | serialRead;
endmodule

// File: rtl/prn_port_chk.sv
module prn_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        addr,
  input logic              csN,
  input logic              rdN,
  input logic              wrN,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              busEn,
  input logic [DATA_W-1:0] pdOut,
  input logic              pdOe,
  input logic              strbN,
  input logic              afdN,
  input logic              initN,
  input logic              slinN,
  input logic              dirCtl,
  input logic              irqOut,
  input logic              irqOe
);
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !wrN && addr == 3'd2) |=>
      (strbN == !$past(wrData[0]) && afdN == !$past(wrData[1]) &&
       initN == !$past(wrData[2]) && slinN == !$past(wrData[3]))); // R2

  AST_FIXED_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !dirCtl |-> pdOe); // R4

  AST_OUT_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN && addr == 3'd0 && pdOe) |-> rdData == pdOut); // R4

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqOe |-> !irqOut); // R10

  AST_BUS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN) |-> busEn); // R11

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rdN && addr > 3'd2) |-> rdData == '0); // R12
endmodule

bind prn_port_ctrl prn_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .csN(csN), .rdN(rdN), .wrN(wrN),
  .wrData(wrData), .rdData(rdData), .busEn(busEn), .pdOut(pdOut),
  .pdOe(pdOe), .strbN(strbN), .afdN(afdN), .initN(initN), .slinN(slinN),
  .dirCtl(dirCtl), .irqOut(irqOut), .irqOe(irqOe)
);

// File: tb/test_prn_port_ctrl.sv
module test_prn_port_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = 3'd0;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       busEn;
  logic       serialRead = 1'b0;
  logic [7:0] pdOut;
  logic [7:0] pdIn = 8'h00;
  logic       pdOe, strbN, afdN, initN, slinN;
  logic       busy = 1'b0, paperOut = 1'b0, selected = 1'b0, errN = 1'b1, ackN = 1'b1;
  logic       irqMode = 1'b0, dirCtl = 1'b0;
  logic       irqOut, irqOe;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prn_port_ctrl i_prn_port_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .csN(csN), .rdN(rdN), .wrN(wrN),
    .wrData(wrData), .rdData(rdData), .busEn(busEn), .serialRead(serialRead),
    .pdOut(pdOut), .pdIn(pdIn), .pdOe(pdOe), .strbN(strbN), .afdN(afdN),
    .initN(initN), .slinN(slinN), .busy(busy), .paperOut(paperOut),
    .selected(selected), .errN(errN), .ackN(ackN), .irqMode(irqMode),
    .dirCtl(dirCtl), .irqOut(irqOut), .irqOe(irqOe)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; csN = 1'b0; wrN = 1'b0;
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d, output logic be);
    @(negedge clk);
    addr = a; csN = 1'b0; rdN = 1'b0;
    #2;
    d = rdData; be = busEn;
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic be;
    check("R1 pins", {4'b0, strbN, afdN, initN, slinN}, 8'h0F);
    check("R1 irqOe", {7'b0, irqOe}, 8'h00);
    rdReg(3'd0, d, be); check("R1 data", d, 8'h00);
    rdReg(3'd2, d, be); check("R1 ctrl", d, 8'h00);
    rdReg(3'd1, d, be); check("R1 flag", {7'b0, d[2]}, 8'h00);
  endtask

  task automatic t_ctrlPins();
    logic [7:0] d; logic be;
    wrReg(3'd2, 8'h05);
    check("R2 pins 05", {4'b0, strbN, afdN, initN, slinN}, 8'h05);
    wrReg(3'd2, 8'h0A);
    check("R2 pins 0A", {4'b0, strbN, afdN, initN, slinN}, 8'h0A);
    wrReg(3'd2, 8'hC3);
    rdReg(3'd2, d, be); check("R3 readback", d, 8'hC3);
    wrReg(3'd2, 8'h00);
  endtask

  task automatic t_fixedDir();
    logic [7:0] d; logic be;
    dirCtl = 1'b0;
    wrReg(3'd2, 8'h20);
    check("R4 pdOe fixed", {7'b0, pdOe}, 8'h01);
    wrReg(3'd0, 8'h5A);
    pdIn = 8'hFF;
    idle(2);
    check("R4 pdOut", pdOut, 8'h5A);
    rdReg(3'd0, d, be); check("R4 data read", d, 8'h5A);
  endtask

  task automatic t_enhDir();
    logic [7:0] d; logic be;
    dirCtl = 1'b1;
    wrReg(3'd2, 8'h20);
    check("R5 pdOe input", {7'b0, pdOe}, 8'h00);
    pdIn = 8'h3C;
    idle(2);
    rdReg(3'd0, d, be); check("R5 sampled read", d, 8'h3C);
    wrReg(3'd2, 8'h00);
    check("R5 pdOe output", {7'b0, pdOe}, 8'h01);
    rdReg(3'd0, d, be); check("R5 latched read", d, 8'h5A);
    dirCtl = 1'b0;
  endtask

  task automatic t_status();
    logic [7:0] d; logic be;
    busy = 1'b1; paperOut = 1'b0; selected = 1'b1; errN = 1'b0;
    idle(3);
    rdReg(3'd1, d, be); check("R6 status D0", d, 8'hD0);
    busy = 1'b0; paperOut = 1'b1; selected = 1'b0; errN = 1'b1;
    idle(3);
    rdReg(3'd1, d, be); check("R6 status 68", d, 8'h68);
  endtask

  task automatic ackPulse();
    ackN = 1'b0; idle(4);
    ackN = 1'b1; idle(5);
  endtask

  task automatic t_flag();
    logic [7:0] d; logic be;
    ackPulse();
    rdReg(3'd1, d, be); check("R7 flag set", {7'b0, d[2]}, 8'h01);
    rdReg(3'd1, d, be); check("R7 flag cleared", {7'b0, d[2]}, 8'h00);
  endtask

  task automatic t_irqMode1();
    logic [7:0] d; logic be;
    irqMode = 1'b1;
    wrReg(3'd2, 8'h10);
    check("R10 irqOe on", {7'b0, irqOe}, 8'h01);
    check("R9 irq idle", {7'b0, irqOut}, 8'h00);
    ackPulse();
    check("R9 irq flag", {7'b0, irqOut}, 8'h01);
    rdReg(3'd1, d, be);
    check("R9 irq cleared", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic t_irqMode0();
    irqMode = 1'b0;
    idle(1);
    check("R8 irq ack high", {7'b0, irqOut}, 8'h01);
    ackN = 1'b0; idle(4);
    check("R8 irq ack low", {7'b0, irqOut}, 8'h00);
    ackN = 1'b1; idle(4);
    check("R8 irq ack rise", {7'b0, irqOut}, 8'h01);
    wrReg(3'd2, 8'h00);
    check("R10 irqOe off", {7'b0, irqOe}, 8'h00);
    check("R10 irq gated", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic t_busEn();
    logic [7:0] d; logic be;
    idle(1);
    check("R11 idle", {7'b0, busEn}, 8'h00);
    serialRead = 1'b1; #1;
    check("R11 serial", {7'b0, busEn}, 8'h01);
    serialRead = 1'b0;
    rdReg(3'd2, d, be); check("R11 port read", {7'b0, be}, 8'h01);
    @(negedge clk);
    addr = 3'd2; wrData = 8'h00; csN = 1'b0; wrN = 1'b0; #2;
    check("R11 write", {7'b0, busEn}, 8'h00);
    @(negedge clk); csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic t_unused();
    logic [7:0] d; logic be;
    wrReg(3'd2, 8'h0C);
    rdReg(3'd5, d, be); check("R12 addr5", d, 8'h00);
    rdReg(3'd7, d, be); check("R12 addr7", d, 8'h00);
    wrReg(3'd1, 8'hFF);
    rdReg(3'd2, d, be); check("R12 ctrl kept", d, 8'h0C);
    rdReg(3'd0, d, be); check("R12 data kept", d, 8'h5A);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_ctrlPins();
    t_fixedDir();
    t_enhDir();
    t_status();
    t_flag();
    t_irqMode1();
    t_irqMode0();
    t_busEn();
    t_unused();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule